// File: doc/BRIEF.md
# Eight-Branch Byte Feistel Encryption Core

This block encrypts one 64-bit block at a time under a 128-bit key, using a generalized Feistel network with eight byte-wide branches. Mixing uses only three operations: addition modulo 256, fixed left rotations inside each byte, and XOR. A block goes through three phases. An input whitening step uses four key bytes. Thirty-two keyed rounds follow. An output whitening step uses four more key bytes.

The core does not hold a key schedule. A separate key-schedule block supplies the eight whitening bytes as one 64-bit word. The core drives a round-index port naming the first round it will compute in the current cycle. The key-schedule block answers in the same cycle with the subkey bytes for that group of rounds. The parameter `RPC` sets how many rounds are unrolled per clock. It must be a power of two from 1 to 32, and a block then takes 32/RPC round cycles.

Input uses a valid/ready handshake. A block is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while a block is in flight, so upstream must hold its data until it sees ready. The output side has no back-pressure. When the result is ready, `done` pulses for one cycle, and `out_block` then holds the ciphertext until the next result replaces it.

Top module: `feistel8_enc_core`

## Requirements
- R1: After reset, `in_ready` is 1, `done` is 0, `out_block` is 0 and `key_round` is 0.
- R2: A block is accepted on an edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` is 0 until the cycle in which `done` is 1.
- R3: `in_valid` asserted while the core is busy is ignored. The ciphertext of the block in flight is unchanged.
- R4: Byte j of a block is bits [8j+7:8j], and whitening byte j is bits [8j+7:8j] of `wkey`. The input whitening sets byte0 to byte0+WK0 and byte4 to byte4+WK2, both mod 256. It sets byte2 to byte2^WK1 and byte6 to byte6^WK3. The odd bytes pass through unchanged.
- R5: With G(x)=rotl1(x)^rotl2(x)^rotl7(x) and H(x)=rotl3(x)^rotl4(x)^rotl6(x), round i uses subkeys S0..S3, which are subkeys 4i..4i+3. It computes four values: a=x1+(H(x0)^S0), b=x3^(G(x2)+S1), c=x5+(H(x4)^S2) and d=x7^(G(x6)+S3). The next state is {x6,c,x4,b,x2,a,x0,d}, listed from byte7 down to byte0.
- R6: Round 31 leaves the branches in place. Its state is {d,x6,c,x4,b,x2,a,x0}. The output whitening then sets byte0 to byte0+WK4, byte2 to byte2^WK5, byte4 to byte4+WK6 and byte6 to byte6^WK7.
- R7: `done` goes to 1 exactly 32/RPC clock edges after the accepting edge, and stays 1 for exactly one cycle.
- R8: While busy, `key_round` equals the index of the first round computed in the current cycle, which is 0, RPC, 2·RPC, and so on. `rk_bytes` bits [32r+8k+7:32r+8k] must carry subkey 4·(key_round+r)+k.
- R9: `out_block` changes only on the edge that raises `done`, and it is held through later idle cycles.
- R10: The ciphertext does not depend on RPC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Plaintext block offered |
| in_ready | output | 1 | Core idle, able to accept |
| in_block | input | 64 | Plaintext, byte j at [8j+7:8j] |
| wkey | input | 64 | Whitening bytes WK0..WK7, WK j at [8j+7:8j] |
| key_round | output | 5 | First round index of the current cycle |
| rk_bytes | input | 32·RPC | Subkeys for rounds key_round..key_round+RPC-1 |
| out_block | output | 64 | Ciphertext, held until the next result |
| done | output | 1 | One-cycle pulse when out_block is updated |

## Verification
The bench builds two instances side by side. One uses RPC=1 and the other RPC=8, and both are fed the same blocks. Each instance has its own key supply, indexed by its own `key_round`. The RPC=1 instance exercises a 32-cycle walk in which every round except the last rotates the branches. The RPC=8 instance exercises the chained generate path, where the last round sits inside an unrolled group. Running both lets the bench check that latency scales with RPC while the ciphertext stays the same. It also lets the bench inject a busy-time `in_valid` while one instance is close to finishing and the other is mid-walk.

// File: rtl/fnet_pkg.sv
package fnet_pkg;
  localparam int BLK_W   = 64;
  localparam int NBYTES  = 8;
  localparam int NROUNDS = 32;

  typedef logic [7:0] byte_t;

  function automatic byte_t rotl8(input byte_t x, input int n);
    return byte_t'((x << n) | (x >> (8 - n)));
  endfunction

  // G mixing function: rotations by 1, 2, 7
  function automatic byte_t mix_g(input byte_t x);
    return rotl8(x, 1) ^ rotl8(x, 2) ^ rotl8(x, 7);
  endfunction

  // H mixing function: rotations by 3, 4, 6
  function automatic byte_t mix_h(input byte_t x);
    return rotl8(x, 3) ^ rotl8(x, 4) ^ rotl8(x, 6);
  endfunction
endpackage

// File: rtl/fnet_whiten.sv
module fnet_whiten
  import fnet_pkg::*;
#(
  parameter bit OUTPUT_SIDE = 1'b0
) (
  input  logic [BLK_W-1:0] din,
  input  logic [BLK_W-1:0] wkey,
  output logic [BLK_W-1:0] dout
);
  localparam int WK_BASE = OUTPUT_SIDE ? 4 : 0;

  byte_t k0, k1, k2, k3;
  assign k0 = wkey[8*(WK_BASE+0) +: 8];
  assign k1 = wkey[8*(WK_BASE+1) +: 8];
  assign k2 = wkey[8*(WK_BASE+2) +: 8];
  assign k3 = wkey[8*(WK_BASE+3) +: 8];

  always_comb begin
    dout        = din;
    dout[7:0]   = din[7:0]   + k0;
    dout[23:16] = din[23:16] ^ k1;
    dout[39:32] = din[39:32] + k2;
    dout[55:48] = din[55:48] ^ k3;
  end
endmodule

// File: rtl/fnet_round.sv
module fnet_round
  import fnet_pkg::*;
(
  input  logic [BLK_W-1:0] din,
  input  logic [31:0]      sk,
  input  logic             final_rnd,
  output logic [BLK_W-1:0] dout
);
  byte_t x [NBYTES];
  byte_t a, b, c, d;

  always_comb begin
    for (int j = 0; j < NBYTES; j++) x[j] = din[8*j +: 8];
    a = x[1] + (mix_h(x[0]) ^ sk[7:0]);
    b = x[3] ^ (mix_g(x[2]) + sk[15:8]);
    c = x[5] + (mix_h(x[4]) ^ sk[23:16]);
    d = x[7] ^ (mix_g(x[6]) + sk[31:24]);
    if (final_rnd) dout = {d, x[6], c, x[4], b, x[2], a, x[0]};
    else           dout = {x[6], c, x[4], b, x[2], a, x[0], d};
  end
endmodule

// File: rtl/fnet_round_chain.sv
module fnet_round_chain
  import fnet_pkg::*;
#(
  parameter int RPC = 4
) (
  input  logic [BLK_W-1:0]  din,
  input  logic [RPC*32-1:0] sk_grp,
  input  logic              last_group,
  output logic [BLK_W-1:0]  dout
);
  logic [BLK_W-1:0] stage [RPC+1];
  assign stage[0] = din;

  for (genvar r = 0; r < RPC; r++) begin : g_rnd
    logic fin;
    if (r == RPC - 1) begin : g_tail
      assign fin = last_group;
    end else begin : g_mid
      assign fin = 1'b0;
    end
    fnet_round u_rnd (
      .din       (stage[r]),
      .sk        (sk_grp[32*r +: 32]),
      .final_rnd (fin),
      .dout      (stage[r+1])
    );
  end

  assign dout = stage[RPC];
endmodule

// File: rtl/feistel8_enc_core.sv
module feistel8_enc_core
  import fnet_pkg::*;
#(
  parameter int RPC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_block,
  input  logic [63:0]       wkey,
  output logic [4:0]        key_round,
  input  logic [RPC*32-1:0] rk_bytes,
  output logic [63:0]       out_block,
  output logic              done
);
  localparam int STEPS  = NROUNDS / RPC;
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic              busy;
  logic [STEP_W-1:0] step;
  logic [BLK_W-1:0]  state;
  logic [BLK_W-1:0]  pre_w, rnd_out, post_w;
  logic              accept, last_group;

  assign in_ready   = !busy;
  assign accept     = in_valid && in_ready;
  assign last_group = (step == STEP_W'(STEPS - 1));
  assign key_round  = 5'(int'(step) * RPC);

  fnet_whiten #(.OUTPUT_SIDE(1'b0)) u_pre (
    .din(in_block), .wkey(wkey), .dout(pre_w)
  );

  fnet_round_chain #(.RPC(RPC)) u_chain (
    .din(state), .sk_grp(rk_bytes), .last_group(last_group), .dout(rnd_out)
  );

  fnet_whiten #(.OUTPUT_SIDE(1'b1)) u_post (
    .din(rnd_out), .wkey(wkey), .dout(post_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      step      <= '0;
      state     <= '0;
      out_block <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        step  <= '0;
        state <= pre_w;
      end else if (busy) begin
        if (last_group) begin
          busy      <= 1'b0;
          step      <= '0;
          out_block <= post_w;
          done      <= 1'b1;
        end else begin
          step  <= step + 1'b1;
          state <= rnd_out;
        end
      end
    end
  end

  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  p_out_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && last_group) |=> $stable(out_block));

  p_round_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_group) |=> (int'(key_round) == int'($past(key_round)) + RPC));

  p_busy_ignores_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_group) |=> !in_ready);
endmodule

// File: tb/feistel8_enc_core_tb_top.sv
module feistel8_enc_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic         in_valid = 1'b0;
  logic [63:0]  in_block = '0;
  logic [127:0] key_q = '0;
  logic [63:0]  wk_q;

  logic         rdy1, rdy8, done1, done8;
  logic [4:0]   kr1, kr8;
  logic [31:0]  rk1;
  logic [255:0] rk8;
  logic [63:0]  out1, out8;

  function automatic logic [7:0] sk_of(input logic [127:0] k, input int idx);
    return 8'(k[8*(idx % 16) +: 8] + 8'(idx * 29));
  endfunction

  function automatic logic [63:0] wk_of(input logic [127:0] k);
    logic [63:0] w;
    for (int j = 0; j < 8; j++) w[8*j +: 8] = k[8*((j + 5) % 16) +: 8] ^ 8'h5a;
    return w;
  endfunction

  function automatic logic [255:0] grp_of(input logic [127:0] k, input int base);
    logic [255:0] g;
    for (int r = 0; r < 8; r++)
      for (int q = 0; q < 4; q++)
        g[32*r + 8*q +: 8] = sk_of(k, 4 * ((base + r) % 32) + q);
    return g;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] x, input int n);
    return 8'((x << n) | (x >> (8 - n)));
  endfunction

  // Reference model written from R4, R5, R6
  function automatic logic [63:0] ref_enc(input logic [63:0] p, input logic [127:0] k);
    logic [7:0] v [8];
    logic [7:0] t [8];
    logic [7:0] w [8];
    logic [7:0] a, b, c, d;
    logic [63:0] res;
    logic [63:0] wk;
    wk = wk_of(k);
    for (int j = 0; j < 8; j++) begin v[j] = p[8*j +: 8]; w[j] = wk[8*j +: 8]; end
    v[0] = v[0] + w[0]; v[2] = v[2] ^ w[1]; v[4] = v[4] + w[2]; v[6] = v[6] ^ w[3];
    for (int i = 0; i < 32; i++) begin
      a = v[1] + ((rl(v[0],3) ^ rl(v[0],4) ^ rl(v[0],6)) ^ sk_of(k, 4*i));
      b = v[3] ^ ((rl(v[2],1) ^ rl(v[2],2) ^ rl(v[2],7)) + sk_of(k, 4*i+1));
      c = v[5] + ((rl(v[4],3) ^ rl(v[4],4) ^ rl(v[4],6)) ^ sk_of(k, 4*i+2));
      d = v[7] ^ ((rl(v[6],1) ^ rl(v[6],2) ^ rl(v[6],7)) + sk_of(k, 4*i+3));
      if (i == 31) begin
        t[0]=v[0]; t[1]=a; t[2]=v[2]; t[3]=b; t[4]=v[4]; t[5]=c; t[6]=v[6]; t[7]=d;
      end else begin
        t[0]=d; t[1]=v[0]; t[2]=a; t[3]=v[2]; t[4]=b; t[5]=v[4]; t[6]=c; t[7]=v[6];
      end
      for (int j = 0; j < 8; j++) v[j] = t[j];
    end
    v[0] = v[0] + w[4]; v[2] = v[2] ^ w[5]; v[4] = v[4] + w[6]; v[6] = v[6] ^ w[7];
    for (int j = 0; j < 8; j++) res[8*j +: 8] = v[j];
    return res;
  endfunction

  assign wk_q = wk_of(key_q);
  assign rk1  = grp_of(key_q, int'(kr1))[31:0];
  assign rk8  = grp_of(key_q, int'(kr8));

  feistel8_enc_core #(.RPC(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1),
    .in_block(in_block), .wkey(wk_q), .key_round(kr1), .rk_bytes(rk1),
    .out_block(out1), .done(done1)
  );

  feistel8_enc_core #(.RPC(8)) dut8_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy8),
    .in_block(in_block), .wkey(wk_q), .key_round(kr8), .rk_bytes(rk8),
    .out_block(out8), .done(done8)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic [63:0] VEC_PT [NV] = '{
    64'h0000_0000_0000_0000, 64'hffff_ffff_ffff_ffff, 64'h0123_4567_89ab_cdef,
    64'h8000_0000_0000_0001, 64'hdead_beef_cafe_f00d, 64'h5a5a_a5a5_3c3c_c3c3 };
  localparam logic [127:0] VEC_KEY [NV] = '{
    128'h0, 128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff,
    128'hffff_ffff_ffff_ffff_ffff_ffff_ffff_ffff, 128'h0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0,
    128'h1357_9bdf_0246_8ace_fdb9_7531_eca8_6420, 128'h8000_0000_0000_0000_0000_0000_0000_0001 };

  task automatic run_block(input logic [63:0] pt, input logic [127:0] k, input bit inject);
    logic [63:0] exp;
    int n1, n8, w1, w8;
    exp = ref_enc(pt, k);
    key_q = k;
    @(negedge clk);
    in_valid = 1'b1;
    in_block = pt;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n1 = 0; n8 = 0; w1 = 0; w8 = 0;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (c == 1) chk(!rdy1 && !rdy8, "R2 busy after accept", {62'd0, rdy1, rdy8}, 64'd0);
      if (inject && c == 2) begin in_valid = 1'b1; in_block = ~pt; end
      if (inject && c == 3) in_valid = 1'b0;
      if (done1) begin w1++; if (n1 == 0) n1 = c; end
      if (done8) begin w8++; if (n8 == 0) n8 = c; end
    end
    chk(out1 == exp, inject ? "R3 busy input ignored RPC=1" : "R4 R5 R6 ciphertext RPC=1", out1, exp);
    chk(out8 == exp, inject ? "R3 busy input ignored RPC=8" : "R10 R8 ciphertext RPC=8", out8, exp);
    chk(n1 == 32 && w1 == 1, "R7 latency/width RPC=1", 64'(n1), 64'd32);
    chk(n8 == 4 && w8 == 1, "R7 latency/width RPC=8", 64'(n8), 64'd4);
    if (inject) chk(out8 == exp, "R9 output held after done", out8, exp);
  endtask

  initial begin
    #35;
    @(negedge clk);
    chk(rdy1 && rdy8, "R1 ready after reset", {62'd0, rdy1, rdy8}, 64'd3);
    chk(!done1 && !done8, "R1 done low after reset", {62'd0, done1, done8}, 64'd0);
    chk(out1 == 0 && out8 == 0, "R1 output zero", out1 | out8, 64'd0);
    chk(kr1 == 0 && kr8 == 0, "R1 key_round zero", 64'(kr1 | kr8), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_block(VEC_PT[i], VEC_KEY[i], 1'b0);
    run_block(64'h1122_3344_5566_7788, 128'h7777_6666_5555_4444_3333_2222_1111_0000, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule